// File: doc/BRIEF.md
# Dual-Rail Lookup Cell With Invalid-Input Hold

This block is a configurable lookup cell for a self-timed fabric. Each logical input and the logical output use level-encoded dual-rail signalling. A logical bit uses two wires: a value rail and a parity rail. The token phase is the XOR of those two rails. A new token always flips the phase, so no spacer is sent between successive values. The function the cell computes is held in a small set of configuration bits, one bit per input combination.

A phase decoder looks at every input token. The tokens must all carry the same phase, and that phase must differ from the phase of the current output. Only then does the decoder pass the combination on to the selection stage. The selection stage reads the addressed configuration bit and drives it out as a new output token in the common input phase. Any combination with mixed phases is stopped at the decoder, so the output keeps its previous token without extra hold multiplexers.

The output token is registered on the clock. The acknowledge is a combinational indication that the output phase has caught up with the common input phase, which is how the completion of a token shows at the port. The number of inputs and the selection structure are parameters.

Top module: `ledr_lut_cell`

## Requirements
- R1: While rst_n is low, y_val and y_par are both 0, so the output phase is 0.
- R2: The phase of a token is its value rail XOR its parity rail. One clock edge after the inputs all carry the same phase P, and P differs from the output phase, the output phase (y_val XOR y_par) equals P.
- R3: On that same edge y_val takes cfg[idx]. Here idx is in_val read as an unsigned number, and in_val[K-1] is the most significant index bit. With K=2, in_val[1] is input A and in_val[0] is input B.
- R4: When the input phases are not all equal, y_val and y_par keep their values at the next edge.
- R5: When all input phases equal the current output phase, the output token is not re-evaluated and stays unchanged.
- R6: Between consecutive clock edges, at most one of the two output rails changes.
- R7: ack is 1 exactly when all input phases are equal and equal to the output phase. It follows the inputs without a clock delay.
- R8: A change on cfg alone, with no new input token, leaves y_val and y_par unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output token register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_val | input | K | Value rails of the K input tokens |
| in_par | input | K | Parity rails of the K input tokens |
| cfg | input | 2**K | Truth table, one bit per input combination |
| y_val | output | 1 | Value rail of the output token |
| y_par | output | 1 | Parity rail of the output token |
| ack | output | 1 | Output phase matches the common input phase |

## Verification
The bench builds the cell with its defaults: K=2, so four table bits, and the AND-OR selection variant. With K=2 a directed sweep can visit every one of the 16 truth tables at all four input combinations. It can also produce every mismatched-phase pair, which exercises the decoder's rejection path completely. Random stimulus with a fixed seed mixes fresh tokens, mismatched tokens, repeated tokens and table changes. This reaches both the hold paths and the one-rail-per-token rule in many different orders.

// File: rtl/ledr_pkg.sv
package ledr_pkg;
   typedef enum logic {
      SEL_ANDOR = 1'b0,
      SEL_INDEX = 1'b1
   } sel_style_e;

   function automatic logic token_phase(input logic v, input logic p);
      return v ^ p;
   endfunction
endpackage

// File: rtl/ledr_phase_decode.sv
module ledr_phase_decode #(
   parameter int K = 2
) (
   input  logic [K-1:0] in_val,
   input  logic [K-1:0] in_par,
   output logic         valid,
   output logic         phase
);
   import ledr_pkg::*;

   logic [K-1:0] ph_vec;

   for (genvar i = 0; i < K; i++) begin : g_ph
      assign ph_vec[i] = token_phase(in_val[i], in_par[i]);
   end

   // all equal: either every phase bit low or every phase bit high
   assign valid = (&ph_vec) | ~(|ph_vec);
   assign phase = ph_vec[0];
endmodule

// File: rtl/ledr_lut_select.sv
module ledr_lut_select #(
   parameter int                   K     = 2,
   parameter ledr_pkg::sel_style_e STYLE = ledr_pkg::SEL_ANDOR,
   localparam int                  NE    = 1 << K
) (
   input  logic          en,
   input  logic [K-1:0]  idx,
   input  logic [NE-1:0] cfg,
   output logic          value
);
   import ledr_pkg::*;

   if (STYLE == SEL_ANDOR) begin : g_andor
      logic [NE-1:0] line;
      for (genvar j = 0; j < NE; j++) begin : g_line
         assign line[j] = en && (idx == K'(j));
      end
      assign value = |(cfg & line);
   end else begin : g_index
      assign value = en ? cfg[idx] : 1'b0;
   end
endmodule

// File: rtl/ledr_token_reg.sv
module ledr_token_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   input  logic phase,
   input  logic new_val,
   output logic y_val,
   output logic y_par,
   output logic out_ph
);
   logic take;

   assign out_ph = y_val ^ y_par;
   assign take   = valid && (phase != out_ph);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y_val <= 1'b0;
         y_par <= 1'b0;
      end else if (take) begin
         y_val <= new_val;
         y_par <= new_val ^ phase;
      end
   end
endmodule

// File: rtl/ledr_lut_cell.sv
module ledr_lut_cell #(
   parameter int                   K     = 2,
   parameter ledr_pkg::sel_style_e STYLE = ledr_pkg::SEL_ANDOR,
   localparam int                  NE    = 1 << K
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [K-1:0]  in_val,
   input  logic [K-1:0]  in_par,
   input  logic [NE-1:0] cfg,
   output logic          y_val,
   output logic          y_par,
   output logic          ack
);
   if (K < 1 || K > 6) begin : g_bad_k
      $error("ledr_lut_cell: K must lie in 1..6");
   end

   logic valid;
   logic phase;
   logic out_ph;
   logic sel_val;

   ledr_phase_decode #(.K(K)) dec_i (
      .in_val (in_val),
      .in_par (in_par),
      .valid  (valid),
      .phase  (phase)
   );

   ledr_lut_select #(.K(K), .STYLE(STYLE)) sel_i (
      .en    (valid),
      .idx   (in_val),
      .cfg   (cfg),
      .value (sel_val)
   );

   ledr_token_reg tok_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (valid),
      .phase   (phase),
      .new_val (sel_val),
      .y_val   (y_val),
      .y_par   (y_par),
      .out_ph  (out_ph)
   );

   assign ack = valid && (phase == out_ph);
endmodule

// File: rtl/ledr_lut_cell_chk.sv
module ledr_lut_cell_chk #(
   parameter int  K  = 2,
   localparam int NE = 1 << K
) (
   input logic          clk,
   input logic          rst_n,
   input logic [K-1:0]  in_val,
   input logic [K-1:0]  in_par,
   input logic [NE-1:0] cfg,
   input logic          y_val,
   input logic          y_par,
   input logic          ack
);
   logic [K-1:0] ph;
   logic         vld;
   logic         fresh;

   assign ph    = in_val ^ in_par;
   assign vld   = (ph == '0) || (ph == '1);
   assign fresh = vld && (ph[0] != (y_val ^ y_par));

   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (!y_val && !y_par));

   a_r2_phase_follows: assert property (@(posedge clk) disable iff (!rst_n)
      fresh |=> ((y_val ^ y_par) == $past(ph[0])));

   a_r3_table_value: assert property (@(posedge clk) disable iff (!rst_n)
      fresh |=> (y_val == $past(cfg[in_val])));

   a_r4_mismatch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !vld |=> ($stable(y_val) && $stable(y_par)));

   a_r5_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !fresh) |=> ($stable(y_val) && $stable(y_par)));

   a_r6_one_rail: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones({y_val, y_par} ^ $past({y_val, y_par})) <= 1));

   a_r7_ack_phase: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> ((y_val ^ y_par) == ph[0]));

   a_r7_ack_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
      !vld |-> !ack);
endmodule

bind ledr_lut_cell ledr_lut_cell_chk #(.K(K)) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .in_val (in_val),
   .in_par (in_par),
   .cfg    (cfg),
   .y_val  (y_val),
   .y_par  (y_par),
   .ack    (ack)
);

// File: tb/ledr_lut_cell_tb_top.sv
`timescale 1ns/1ps
module ledr_lut_cell_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] in_val = '0;
   logic [1:0] in_par = '0;
   logic [3:0] cfg = '0;
   logic       y_val, y_par, ack;

   int checks = 0;
   int failures = 0;

   // bench model of the output token
   logic m_val = 1'b0;
   logic m_ph  = 1'b0;
   logic prev_val = 1'b0;
   logic prev_par = 1'b0;

   always #10 clk = ~clk;

   ledr_lut_cell dut_i (
      .clk(clk), .rst_n(rst_n), .in_val(in_val), .in_par(in_par),
      .cfg(cfg), .y_val(y_val), .y_par(y_par), .ack(ack)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   function automatic logic exp_ack(input logic [1:0] v, input logic [1:0] p, input logic mph);
      logic pa, pb;
      pa = v[1] ^ p[1];
      pb = v[0] ^ p[0];
      return (pa == pb) && (pa == mph);
   endfunction

   // drive inputs; the model takes effect at the next rising edge
   task automatic apply(input logic av, input logic ap, input logic bv,
                        input logic bp, input logic [3:0] c);
      logic pa, pb;
      in_val = {av, bv};
      in_par = {ap, bp};
      cfg    = c;
      pa = av ^ ap;
      pb = bv ^ bp;
      if (pa == pb && pa != m_ph) begin
         m_val = c[{av, bv}];
         m_ph  = pa;
      end
   endtask

   task automatic sample(input string tag);
      @(negedge clk);
      chk({tag, " R3 y_val"}, y_val, m_val);
      chk({tag, " R2 phase"}, y_val ^ y_par, m_ph);
      chk({tag, " R7 ack"}, ack, exp_ack(in_val, in_par, m_ph));
      chk({tag, " R6 one rail"}, ((y_val ^ prev_val) + (y_par ^ prev_par)) <= 1, 1'b1);
      prev_val = y_val;
      prev_par = y_par;
   endtask

   initial begin : watchdog
      #(200000 * 20);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      logic tp, nv_a, nv_b, pa;
      int mode;
      seed = 32'd7365;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      chk("R1 reset y_val", y_val, 1'b0);
      chk("R1 reset y_par", y_par, 1'b0);
      rst_n = 1'b1;
      sample("R1 after release");

      // R3 full sweep: every table, every combination
      for (int c = 0; c < 16; c++) begin
         for (int i = 0; i < 4; i++) begin
            tp = ~m_ph;
            apply(i[1], i[1] ^ tp, i[0], i[0] ^ tp, c[3:0]);
            sample("R3 sweep");
         end
      end

      // R4 mismatched phases hold the output
      apply(1'b1, 1'b1, 1'b0, 1'b1, 4'hF);   // pa=0 pb=1
      sample("R4 mismatch");
      apply(1'b0, 1'b1, 1'b1, 1'b1, 4'h0);   // pa=1 pb=0
      sample("R4 mismatch");

      // R5 token already consumed: re-present and change value rails
      tp = ~m_ph;
      apply(1'b0, tp, 1'b0, tp, 4'h1);
      sample("R5 fresh");
      apply(1'b1, ~tp, 1'b1, ~tp, 4'h8);     // same phase, other values
      sample("R5 no re-eval");

      // R8 table change alone
      apply(in_val[1], in_par[1], in_val[0], in_par[0], ~cfg);
      sample("R8 cfg only");
      apply(in_val[1], in_par[1], in_val[0], in_par[0], 4'h5);
      sample("R8 cfg only");

      // random mix
      for (int n = 0; n < 600; n++) begin
         mode = $urandom_range(0, 9);
         nv_a = 1'($urandom);
         nv_b = 1'($urandom);
         if (mode <= 4) begin
            tp = ~m_ph;
            apply(nv_a, nv_a ^ tp, nv_b, nv_b ^ tp, cfg);
            sample("R2 random fresh");
         end else if (mode <= 6) begin
            pa = 1'($urandom);
            apply(nv_a, nv_a ^ pa, nv_b, nv_b ^ ~pa, 4'($urandom));
            sample("R4 random mismatch");
         end else if (mode == 7) begin
            apply(nv_a, nv_a ^ m_ph, nv_b, nv_b ^ m_ph, cfg);
            sample("R5 random same phase");
         end else begin
            apply(in_val[1], in_par[1], in_val[0], in_par[0], 4'($urandom));
            sample("R8 random cfg");
         end
      end

      // R1 reset again mid-run
      tp = ~m_ph;
      apply(1'b1, 1'b1 ^ tp, 1'b1, 1'b1 ^ tp, 4'h8);
      sample("R3 before reset");
      rst_n = 1'b0;
      m_val = 1'b0;
      m_ph  = 1'b0;
      #1;
      chk("R1 async reset y_val", y_val, 1'b0);
      chk("R1 async reset y_par", y_par, 1'b0);
      apply(1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
      @(negedge clk);
      rst_n = 1'b1;
      prev_val = 1'b0;
      prev_par = 1'b0;
      sample("R7 reset phase match");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule